// File: doc/BRIEF.md
# IDE Host Configuration Unlock Block

This block models the hidden configuration logic of a legacy IDE host controller as seen from the host I/O bus. It watches every byte read and write the host makes on the task-file ports. When the top bit of the sector-count port has been set, a fixed order of five reads switches the block into a programming mode. Completion of that order is made visible by the top bit of the sector-count port reading back as zero. A host can tell this controller apart from one without the feature by that bit alone.

While programming mode is active, the host can write two configuration bytes. The speed byte carries a three-bit speed field for the master device and one for the slave device, plus a bus-clock range flag and a top-speed flag. The control byte carries an enable for an index/data port pair. That pair reaches eight extended bytes: two timing bytes per device and a status byte. The status byte records DMA completion and error pulses and clears when it is read. A read of the exit port leaves programming mode. The decoded speed fields and the per-device timing words are driven as outputs for the timing generator. The block claims a read by raising `io_rvalid` together with `io_rdata` one cycle after the read strobe.

Top module: `ide_cfg_unlock`

## Requirements
- R1: After a synchronous reset, programming mode is off, the sector-count top bit is 0, `io_rvalid` is 0, the control byte is 0, and the speed byte holds bits 7:3 = 0 and bits 2:0 = `strap_spd` * 2, so `slv_speed` can only take 0, 2, 4 or 6.
- R2: A write to port 0x1F2 stores data bit 7 as the sector-count top bit. A read of 0x1F2 is always claimed and returns that bit in bit 7, with bits 6:0 at 0. Each claimed read raises `io_rvalid` for one cycle, one cycle after the strobe.
- R3: While the top bit is 1 and the block is outside programming mode, five reads in the order 0x1F2, 0x3F6, 0x3F6, 0x1F2, 0x1F2 enter programming mode. The fifth read still returns 0x80, and later reads of 0x1F2 return 0x00.
- R4: A read of any other port breaks a partial order, and the block stays out of programming mode with the top bit at 1. A read of 0x1F2 where 0x3F6 was expected restarts the order as its first step. Reads made while the top bit is 0 never enter the mode.
- R5: Any read of port 0x1F5 leaves programming mode. That read is not claimed.
- R6: Port 0x1F3 is the speed byte: bits 5:3 give `mst_speed`, bits 2:0 give `slv_speed`, bit 6 gives `bus_slow` (1 means bus clock at or below 33 MHz), and bit 7 gives `top_speed`. It is written and read back only in programming mode. Outside the mode, writes leave it unchanged and reads are not claimed.
- R7: Port 0x1F4 is the control byte. It is written and read only in programming mode, and its bit 3 enables ports 0x1F8 and 0x1F9 in or out of the mode. When bit 3 is 0, reads of those ports are not claimed and writes to them change nothing.
- R8: A write to 0x1F8 sets a 3-bit index from data bits 2:0, and a read returns the index in bits 2:0 with bits 7:3 at 0. Port 0x1F9 writes and reads the indexed byte. `mst_timing` = {byte 1, byte 0} and `slv_timing` = {byte 3, byte 2}.
- R9: Byte 7 is status. A pulse on `dma_wr_done` sets bit 0, `dma_rd_done` sets bit 1, and `dma_err` sets bit 4; all other bits read 0. A read of byte 7 returns the flags and clears them, and writes to byte 7 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_stb | input | 1 | One-cycle I/O access strobe |
| io_wr | input | 1 | 1 = write access, 0 = read access |
| io_addr | input | 10 | I/O port address |
| io_wdata | input | 8 | Write data byte |
| strap_spd | input | 2 | Jumper straps for the reset slave speed (speed = value * 2) |
| dma_wr_done | input | 1 | Pulse: DMA write finished |
| dma_rd_done | input | 1 | Pulse: DMA read finished |
| dma_err | input | 1 | Pulse: DMA error |
| io_rdata | output | 8 | Read data, valid with io_rvalid |
| io_rvalid | output | 1 | Read claimed by this block |
| prog_mode | output | 1 | Programming mode active |
| mst_speed | output | 3 | Master device speed setting |
| slv_speed | output | 3 | Slave device speed setting |
| bus_slow | output | 1 | Bus clock range flag |
| top_speed | output | 1 | Top-speed flag |
| mst_timing | output | 16 | Master timing word |
| slv_timing | output | 16 | Slave timing word |

## Verification
The unlock detector is driven with the exact five-read order, with an order broken by an unrelated port, with an order where a repeated 0x1F2 read must restart rather than abort, and with a full order while unarmed. Together these separate a correct detector from one that only counts reads, ignores addresses, or fails to restart. The configuration ports are written both inside and outside programming mode, and the extended pair is used with its enable set and cleared, so that gating faults show up at the read-back and field outputs. The status byte is read twice and written, which shows that flags are set, that reads clear them, and that writes have no effect.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;
  localparam int unsigned ADDR_W = 10;
  localparam int unsigned DATA_W = 8;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_GOT_SC1,
    SQ_GOT_ALT1,
    SQ_GOT_ALT2,
    SQ_GOT_SC2
  } seq_state_e;
endpackage

// File: rtl/ide_unlock_seq.sv
module ide_unlock_seq
  import ide_cfg_pkg::*;
#(
  parameter int unsigned AW        = 10,
  parameter logic [AW-1:0] SC_PORT   = 10'h1F2,
  parameter logic [AW-1:0] ALT_PORT  = 10'h3F6,
  parameter logic [AW-1:0] EXIT_PORT = 10'h1F5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_stb,
  input  logic          wr_stb,
  input  logic [AW-1:0] addr,
  input  logic          wbit,
  output logic          sc_msb,
  output logic          prog_mode
);
  seq_state_e st_q;
  logic is_sc, is_alt;

  assign is_sc  = (addr == SC_PORT);
  assign is_alt = (addr == ALT_PORT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SQ_IDLE;
      sc_msb    <= 1'b0;
      prog_mode <= 1'b0;
    end else begin
      if (wr_stb && is_sc) sc_msb <= wbit;
      if (rd_stb) begin
        if (addr == EXIT_PORT) prog_mode <= 1'b0;
        if (sc_msb && !prog_mode) begin
          case (st_q)
            SQ_IDLE:     st_q <= is_sc ? SQ_GOT_SC1 : SQ_IDLE;
            SQ_GOT_SC1:  st_q <= is_alt ? SQ_GOT_ALT1 : (is_sc ? SQ_GOT_SC1 : SQ_IDLE);
            SQ_GOT_ALT1: st_q <= is_alt ? SQ_GOT_ALT2 : (is_sc ? SQ_GOT_SC1 : SQ_IDLE);
            SQ_GOT_ALT2: st_q <= is_sc ? SQ_GOT_SC2 : SQ_IDLE;
            SQ_GOT_SC2: begin
              st_q <= SQ_IDLE;
              if (is_sc) begin
                prog_mode <= 1'b1;
                sc_msb    <= 1'b0;
              end
            end
            default:     st_q <= SQ_IDLE;
          endcase
        end else begin
          st_q <= SQ_IDLE;
        end
      end
    end
  end

  AST_EXIT_ON_PORT: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && addr == EXIT_PORT) |=> !prog_mode); // R5
  AST_ENTRY_NEEDS_ARM: assert property (@(posedge clk) disable iff (rst)
    $rose(prog_mode) |-> ($past(sc_msb) && $past(rd_stb) && !sc_msb)); // R3
endmodule

// File: rtl/ide_ext_regs.sv
module ide_ext_regs #(
  parameter int unsigned DW         = 8,
  parameter int unsigned IDX_W      = 3,
  parameter int unsigned STATUS_IDX = 7
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            idx_wr,
  input  logic            dat_wr,
  input  logic            dat_rd,
  input  logic [DW-1:0]   wdata,
  input  logic            dma_wr_done,
  input  logic            dma_rd_done,
  input  logic            dma_err,
  output logic [IDX_W-1:0] idx,
  output logic [DW-1:0]   dat_rdata,
  output logic [2*DW-1:0] mst_timing,
  output logic [2*DW-1:0] slv_timing
);
  localparam int unsigned NREG = 1 << IDX_W;

  logic [DW-1:0] bank [NREG];
  logic st_wr, st_rd, st_err;
  logic [DW-1:0] status_byte;
  logic is_status;

  assign is_status = (idx == IDX_W'(STATUS_IDX));

  always_comb begin
    status_byte    = '0;
    status_byte[0] = st_wr;
    status_byte[1] = st_rd;
    status_byte[4] = st_err;
  end

  always_ff @(posedge clk) begin
    if (rst) idx <= '0;
    else if (idx_wr) idx <= wdata[IDX_W-1:0];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst) bank[g] <= '0;
      else if (dat_wr && idx == IDX_W'(g) && g != STATUS_IDX) bank[g] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_wr  <= 1'b0;
      st_rd  <= 1'b0;
      st_err <= 1'b0;
    end else begin
      st_wr  <= (st_wr  && !(dat_rd && is_status)) || dma_wr_done;
      st_rd  <= (st_rd  && !(dat_rd && is_status)) || dma_rd_done;
      st_err <= (st_err && !(dat_rd && is_status)) || dma_err;
    end
  end

  assign dat_rdata  = is_status ? status_byte : bank[idx];
  assign mst_timing = {bank[1], bank[0]};
  assign slv_timing = {bank[3], bank[2]};

  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (dat_rd && is_status && !dma_wr_done && !dma_rd_done && !dma_err)
      |=> (status_byte == '0)); // R9
  AST_PULSE_SETS: assert property (@(posedge clk) disable iff (rst)
    dma_err |=> st_err); // R9
endmodule

// File: rtl/ide_cfg_unlock.sv
module ide_cfg_unlock
  import ide_cfg_pkg::*;
#(
  parameter int unsigned AW      = ADDR_W,
  parameter int unsigned DW      = DATA_W,
  parameter int unsigned SPD_W   = 3,
  parameter int unsigned STRAP_W = 2,
  parameter int unsigned IDX_W   = 3,
  parameter logic [AW-1:0] P_SC   = 10'h1F2,
  parameter logic [AW-1:0] P_SPD  = 10'h1F3,
  parameter logic [AW-1:0] P_CTL  = 10'h1F4,
  parameter logic [AW-1:0] P_EXIT = 10'h1F5,
  parameter logic [AW-1:0] P_IDX  = 10'h1F8,
  parameter logic [AW-1:0] P_DAT  = 10'h1F9,
  parameter logic [AW-1:0] P_ALT  = 10'h3F6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               io_stb,
  input  logic               io_wr,
  input  logic [AW-1:0]      io_addr,
  input  logic [DW-1:0]      io_wdata,
  input  logic [STRAP_W-1:0] strap_spd,
  input  logic               dma_wr_done,
  input  logic               dma_rd_done,
  input  logic               dma_err,
  output logic [DW-1:0]      io_rdata,
  output logic               io_rvalid,
  output logic               prog_mode,
  output logic [SPD_W-1:0]   mst_speed,
  output logic [SPD_W-1:0]   slv_speed,
  output logic               bus_slow,
  output logic               top_speed,
  output logic [2*DW-1:0]    mst_timing,
  output logic [2*DW-1:0]    slv_timing
);
  localparam int unsigned EXT_EN_BIT = 3;

  logic rd_stb, wr_stb, sc_msb, ext_en, rd_hit;
  logic is_ext;
  logic [DW-1:0] spd_q, ctl_q, rd_mux, ext_rdata;
  logic [IDX_W-1:0] ext_idx;

  assign rd_stb = io_stb && !io_wr;
  assign wr_stb = io_stb && io_wr;
  assign ext_en = ctl_q[EXT_EN_BIT];
  assign is_ext = (io_addr == P_IDX) || (io_addr == P_DAT);

  ide_unlock_seq #(
    .AW(AW), .SC_PORT(P_SC), .ALT_PORT(P_ALT), .EXIT_PORT(P_EXIT)
  ) u_seq (
    .clk(clk), .rst(rst), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .addr(io_addr), .wbit(io_wdata[DW-1]),
    .sc_msb(sc_msb), .prog_mode(prog_mode)
  );

  ide_ext_regs #(
    .DW(DW), .IDX_W(IDX_W), .STATUS_IDX((1 << IDX_W) - 1)
  ) u_ext (
    .clk(clk), .rst(rst),
    .idx_wr(wr_stb && ext_en && io_addr == P_IDX),
    .dat_wr(wr_stb && ext_en && io_addr == P_DAT),
    .dat_rd(rd_stb && ext_en && io_addr == P_DAT),
    .wdata(io_wdata),
    .dma_wr_done(dma_wr_done), .dma_rd_done(dma_rd_done), .dma_err(dma_err),
    .idx(ext_idx), .dat_rdata(ext_rdata),
    .mst_timing(mst_timing), .slv_timing(slv_timing)
  );

  always_comb begin
    rd_hit = 1'b0;
    rd_mux = '0;
    if (io_addr == P_SC) begin
      rd_hit = 1'b1;
      rd_mux[DW-1] = sc_msb;
    end else if (prog_mode && io_addr == P_SPD) begin
      rd_hit = 1'b1;
      rd_mux = spd_q;
    end else if (prog_mode && io_addr == P_CTL) begin
      rd_hit = 1'b1;
      rd_mux = ctl_q;
    end else if (ext_en && io_addr == P_IDX) begin
      rd_hit = 1'b1;
      rd_mux[IDX_W-1:0] = ext_idx;
    end else if (ext_en && io_addr == P_DAT) begin
      rd_hit = 1'b1;
      rd_mux = ext_rdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      spd_q     <= {{(DW-SPD_W){1'b0}}, strap_spd, 1'b0};
      ctl_q     <= '0;
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_rvalid <= rd_stb && rd_hit;
      io_rdata  <= (rd_stb && rd_hit) ? rd_mux : '0;
      if (wr_stb && prog_mode && io_addr == P_SPD) spd_q <= io_wdata;
      if (wr_stb && prog_mode && io_addr == P_CTL) ctl_q <= io_wdata;
    end
  end

  assign slv_speed = spd_q[SPD_W-1:0];
  assign mst_speed = spd_q[2*SPD_W-1:SPD_W];
  assign bus_slow  = spd_q[DW-2];
  assign top_speed = spd_q[DW-1];

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!prog_mode && !io_rvalid && ctl_q == '0)); // R1
  AST_RVALID_CAUSE: assert property (@(posedge clk) disable iff (rst)
    io_rvalid |-> $past(rd_stb)); // R2
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !prog_mode) |=> ($stable(spd_q) && $stable(ctl_q))); // R6
  AST_EXT_SILENT: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !ext_en && is_ext) |=> !io_rvalid); // R7
endmodule

// File: tb/ide_cfg_unlock_bench.sv
`timescale 1ns/1ps
module ide_cfg_unlock_bench;
  localparam real CLK_NS = 20.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_stb = 1'b0, io_wr = 1'b0;
  logic [9:0]  io_addr = '0;
  logic [7:0]  io_wdata = '0;
  logic [1:0]  strap_spd = 2'd3;
  logic        dma_wr_done = 1'b0, dma_rd_done = 1'b0, dma_err = 1'b0;
  logic [7:0]  io_rdata;
  logic        io_rvalid, prog_mode, bus_slow, top_speed;
  logic [2:0]  mst_speed, slv_speed;
  logic [15:0] mst_timing, slv_timing;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  ide_cfg_unlock u_ide_cfg_unlock (
    .clk(clk), .rst(rst), .io_stb(io_stb), .io_wr(io_wr), .io_addr(io_addr),
    .io_wdata(io_wdata), .strap_spd(strap_spd), .dma_wr_done(dma_wr_done),
    .dma_rd_done(dma_rd_done), .dma_err(dma_err), .io_rdata(io_rdata),
    .io_rvalid(io_rvalid), .prog_mode(prog_mode), .mst_speed(mst_speed),
    .slv_speed(slv_speed), .bus_slow(bus_slow), .top_speed(top_speed),
    .mst_timing(mst_timing), .slv_timing(slv_timing)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [9:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    io_stb = 1'b1; io_wr = 1'b0; io_addr = a;
    @(negedge clk);
    io_stb = 1'b0;
    d = io_rdata; v = io_rvalid;
  endtask

  task automatic wr(input logic [9:0] a, input logic [7:0] d);
    @(negedge clk);
    io_stb = 1'b1; io_wr = 1'b1; io_addr = a; io_wdata = d;
    @(negedge clk);
    io_stb = 1'b0; io_wr = 1'b0;
  endtask

  task automatic enter_mode();
    logic [7:0] d; logic v;
    wr(10'h1F2, 8'h80);
    rd(10'h1F2, d, v); rd(10'h3F6, d, v); rd(10'h3F6, d, v);
    rd(10'h1F2, d, v); rd(10'h1F2, d, v);
  endtask

  task automatic t_reset();
    chk("R1 prog_mode", prog_mode, 0);
    chk("R1 rvalid", io_rvalid, 0);
    chk("R1 slv_speed strap", slv_speed, 6);
    chk("R1 mst_speed", mst_speed, 0);
    chk("R1 flags", {top_speed, bus_slow}, 0);
  endtask

  task automatic t_sc_bit();
    logic [7:0] d; logic v;
    rd(10'h1F2, d, v);
    chk("R2 sc read valid", v, 1);
    chk("R2 sc read after reset", d, 8'h00);
    wr(10'h1F2, 8'hFF);
    rd(10'h1F2, d, v);
    chk("R2 sc bit7 set", d, 8'h80);
    @(negedge clk);
    chk("R2 rvalid one cycle", io_rvalid, 0);
  endtask

  task automatic t_unlock();
    logic [7:0] d; logic v;
    wr(10'h1F2, 8'h80);
    rd(10'h1F2, d, v); rd(10'h3F6, d, v); rd(10'h3F6, d, v); rd(10'h1F2, d, v);
    chk("R3 not yet in mode", prog_mode, 0);
    rd(10'h1F2, d, v);
    chk("R3 fifth read still 0x80", d, 8'h80);
    chk("R3 mode entered", prog_mode, 1);
    rd(10'h1F2, d, v);
    chk("R3 bit7 cleared", d, 8'h00);
  endtask

  task automatic t_exit();
    logic [7:0] d; logic v;
    rd(10'h1F5, d, v);
    chk("R5 exit read unclaimed", v, 0);
    chk("R5 mode left", prog_mode, 0);
  endtask

  task automatic t_broken();
    logic [7:0] d; logic v;
    wr(10'h1F2, 8'h80);
    rd(10'h1F2, d, v); rd(10'h3F6, d, v); rd(10'h1F7, d, v);
    rd(10'h3F6, d, v); rd(10'h1F2, d, v); rd(10'h1F2, d, v);
    chk("R4 broken order stays out", prog_mode, 0);
    rd(10'h1F2, d, v);
    chk("R4 bit7 stays set", d, 8'h80);
    rd(10'h1F2, d, v); rd(10'h3F6, d, v); rd(10'h3F6, d, v);
    rd(10'h1F2, d, v); rd(10'h1F2, d, v);
    chk("R4 restart on repeated 1F2", prog_mode, 1);
    t_exit();
    wr(10'h1F2, 8'h00);
    rd(10'h1F2, d, v); rd(10'h3F6, d, v); rd(10'h3F6, d, v);
    rd(10'h1F2, d, v); rd(10'h1F2, d, v);
    chk("R4 unarmed never enters", prog_mode, 0);
  endtask

  task automatic t_speed();
    logic [7:0] d; logic v;
    enter_mode();
    wr(10'h1F3, 8'hDD);
    chk("R6 mst_speed", mst_speed, 3);
    chk("R6 slv_speed", slv_speed, 5);
    chk("R6 top/bus flags", {top_speed, bus_slow}, 3);
    rd(10'h1F3, d, v);
    chk("R6 readback", d, 8'hDD);
    t_exit();
    wr(10'h1F3, 8'h00);
    chk("R6 locked write", slv_speed, 5);
    rd(10'h1F3, d, v);
    chk("R6 read unclaimed outside mode", v, 0);
  endtask

  task automatic t_ext();
    logic [7:0] d; logic v;
    rd(10'h1F8, d, v);
    chk("R7 disabled index unclaimed", v, 0);
    wr(10'h1F4, 8'h08);
    wr(10'h1F8, 8'h02);
    enter_mode();
    wr(10'h1F4, 8'h08);
    rd(10'h1F4, d, v);
    chk("R7 ctl readback", d, 8'h08);
    t_exit();
    wr(10'h1F8, 8'hFA);
    rd(10'h1F8, d, v);
    chk("R8 index read", d, 8'h02);
    wr(10'h1F9, 8'hA5);
    wr(10'h1F8, 8'h03); wr(10'h1F9, 8'h5A);
    wr(10'h1F8, 8'h00); wr(10'h1F9, 8'h11);
    wr(10'h1F8, 8'h01); wr(10'h1F9, 8'h22);
    chk("R8 slv_timing", slv_timing, 16'h5AA5);
    chk("R8 mst_timing", mst_timing, 16'h2211);
    wr(10'h1F8, 8'h02);
    rd(10'h1F9, d, v);
    chk("R8 data readback", d, 8'hA5);
    enter_mode();
    wr(10'h1F4, 8'h00);
    t_exit();
    wr(10'h1F8, 8'h00); wr(10'h1F9, 8'h77);
    rd(10'h1F9, d, v);
    chk("R7 disabled data unclaimed", v, 0);
    enter_mode();
    wr(10'h1F4, 8'h08);
    t_exit();
    rd(10'h1F8, d, v);
    chk("R7 disabled index write ignored", d, 8'h02);
    chk("R7 disabled data write ignored", slv_timing, 16'h5AA5);
  endtask

  task automatic t_status();
    logic [7:0] d; logic v;
    wr(10'h1F8, 8'h07);
    @(negedge clk); dma_err = 1'b1; dma_wr_done = 1'b1;
    @(negedge clk); dma_err = 1'b0; dma_wr_done = 1'b0;
    rd(10'h1F9, d, v);
    chk("R9 status flags", d, 8'h11);
    rd(10'h1F9, d, v);
    chk("R9 read clears", d, 8'h00);
    @(negedge clk); dma_rd_done = 1'b1;
    @(negedge clk); dma_rd_done = 1'b0;
    wr(10'h1F9, 8'hFF);
    rd(10'h1F9, d, v);
    chk("R9 write ignored, rd flag", d, 8'h02);
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sc_bit();
    t_unlock();
    t_exit();
    t_broken();
    t_speed();
    t_ext();
    t_status();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule